// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of N bits each and returns their full 2N-bit signed product. It recodes the multiplier `y` into signed radix-4 digits from {-2, -1, 0, +1, +2}. Each digit comes from a window of three adjacent bits of `y`, and consecutive windows share one bit. A zero bit is placed below bit 0 of `y` to complete the lowest window. In each step, one adder/subtractor adds the multiple of `x` that the digit selects to a running sum. So the block finishes in N/2 steps, not the N steps of a plain shift-and-add design.

A caller holds `x` and `y` and raises `start` for one cycle while `busy` is low. The block then runs for N/2 cycles. After that it raises `done` and presents `product`. Both stay unchanged until the next start is accepted. Any start that arrives while the block is busy is dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: For every accepted pair, `product` equals the signed product x*y, as a 2N-bit two's-complement value.
- R3: The digit read from a window (b2 b1 b0, where b2 is the most significant bit) is: 000 gives 0, 001 gives +x, 010 gives +x, 011 gives +2x, 100 gives -2x, 101 gives -x, 110 gives -x, 111 gives 0. A zero digit adds nothing.
- R4: The first window is (y[1], y[0], 0). Window k is (y[2k+1], y[2k], y[2k-1]), and its digit carries weight 4^k.
- R5: When `start` is sampled high with `busy` low at rising edge E, `busy` is high from edge E to edge E+N/2-1. `done` rises at edge E+N/2, with no extra cycle for the last step.
- R6: A `start` sampled while `busy` is high is ignored. The step sequence continues, and the product of the running operation is not changed.
- R7: `done` and `product` keep their values until the next accepted `start`. Acceptance clears `done` at that same edge.
- R8: The product of the most negative operand with itself, (-2^(N-1))*(-2^(N-1)) = 2^(2N-2), is returned without overflow. The running sum is sign-extended to 2N+1 bits.
- R9: A negative digit is formed on the shared adder by inverting every bit of the selected magnitude and driving the carry-in to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when `busy` is low |
| x | input | N | Signed multiplicand, sampled on acceptance |
| y | input | N | Signed multiplier, sampled on acceptance |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | High from completion until the next accepted start |
| product | output | 2N | Signed product of the last completed operation |

## Verification
The assertions assume two things about the inputs. First, `start` changes only between clock edges. Second, `x` and `y` are stable at the accepting edge, because later edges ignore them. The bench drives `start`, `x` and `y` only on falling edges. It lowers `start` one cycle after a request, except in the deliberate stray-start test, where it changes the operands while the block is busy. Because every window pattern and the most negative operand turn up only with particular operand values, the stimulus sweeps all 256 multiplicands against a fixed set of multipliers. That set covers each window code in each digit position, plus the extreme values.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Selected multiple for one radix-4 digit: magnitude one or two, optional negate.
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_sel_t;

   localparam booth_sel_t SEL_ZERO = '{neg: 1'b0, one: 1'b0, two: 1'b0};

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic [2:0] window,
   output booth_sel_t sel
);

   always_comb begin
      sel = SEL_ZERO;
      unique case (window)
         3'b001, 3'b010: sel = '{neg: 1'b0, one: 1'b1, two: 1'b0};
         3'b011:         sel = '{neg: 1'b0, one: 1'b0, two: 1'b1};
         3'b100:         sel = '{neg: 1'b1, one: 1'b0, two: 1'b1};
         3'b101, 3'b110: sel = '{neg: 1'b1, one: 1'b1, two: 1'b0};
         default:        sel = SEL_ZERO;
      endcase
   end

endmodule

// File: rtl/booth_multiple_sel.sv
module booth_multiple_sel
   import booth_pkg::*;
#(
   parameter int W = 17
) (
   input  logic [W-1:0] mcand,
   input  booth_sel_t   sel,
   output logic [W-1:0] addend,
   output logic         cin
);

   logic [W-1:0] mag;

   always_comb begin
      if (sel.two)      mag = {mcand[W-2:0], 1'b0};
      else if (sel.one) mag = mcand;
      else              mag = '0;
   end

   // Negation: bitwise invert here, plus one through the adder carry-in.
   assign addend = mag ^ {W{sel.neg}};
   assign cin    = sel.neg;

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
   parameter int W      = 17,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b[i] ^ c[i];
            if (i < W-1) begin : g_carry
               assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
            end
         end
      end else begin : g_behav
         assign sum = a + b + {{(W-1){1'b0}}, cin};
      end
   endgenerate

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int N      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N-1:0]   x,
   input  logic [N-1:0]   y,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);

   localparam int AW    = 2*N + 1;
   localparam int STEPS = N / 2;
   localparam int SW    = $clog2(STEPS + 1);
   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   generate
      if ((N < 2) || (N % 2 != 0)) begin : g_bad_width
         initial $fatal(1, "booth_seq_mult: N must be even and at least 2");
      end
   endgenerate

   logic           busy_q, done_q;
   logic [SW-1:0]  step_q;
   logic [AW-1:0]  acc_q, mcand_q, sum, addend;
   logic [N:0]     ybits_q;
   logic [2*N-1:0] prod_q;
   logic           cin, accept;
   logic [2:0]     window;
   booth_sel_t     sel;

   assign accept = start && !busy_q;
   assign window = ybits_q[2:0];

   booth_recoder u_rec (
      .window (window),
      .sel    (sel)
   );

   booth_multiple_sel #(.W(AW)) u_sel (
      .mcand  (mcand_q),
      .sel    (sel),
      .addend (addend),
      .cin    (cin)
   );

   booth_addsub #(.W(AW), .RIPPLE(RIPPLE)) u_add (
      .a   (acc_q),
      .b   (addend),
      .cin (cin),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         step_q  <= '0;
         acc_q   <= '0;
         mcand_q <= '0;
         ybits_q <= '0;
         prod_q  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
         step_q  <= '0;
         acc_q   <= '0;
         mcand_q <= {{(N+1){x[N-1]}}, x};
         ybits_q <= {y, 1'b0};
      end else if (busy_q) begin
         acc_q   <= sum;
         mcand_q <= {mcand_q[AW-3:0], 2'b00};
         ybits_q <= {{2{ybits_q[N]}}, ybits_q[N:2]};
         step_q  <= step_q + SW'(1);
         if (step_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            prod_q <= sum[2*N-1:0];
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign product = prod_q;

   // Acceptance opens a fresh run (R5, R7).
   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> (busy_q && !done_q && step_q == '0));

   // Last step completes without an extra cycle (R5).
   p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && step_q == LAST) |=> (!busy_q && done_q));

   // Stray start during a run does not disturb the step sequence (R6).
   p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && step_q != LAST) |=> (busy_q && step_q == $past(step_q) + SW'(1)));

   // Result held while no new request arrives (R7).
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> (done_q && $stable(prod_q)));

   // Final sum fits in 2N signed bits (R8).
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && step_q == LAST) |=> (acc_q[AW-1] == acc_q[2*N-1]));

   // Zero windows contribute nothing to the adder (R3).
   p_zero_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (window == 3'b000 || window == 3'b111)) |-> (addend == '0 && !cin));

   // -2x is an inverted doubled multiplicand plus carry-in (R9).
   p_neg_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && window == 3'b100) |-> (addend == ~{mcand_q[AW-2:0], 1'b0} && cin));

endmodule

// File: tb/booth_seq_mult_tb_top.sv
module booth_seq_mult_tb_top;

   localparam int N = 8;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic signed [N-1:0]   x = '0;
   logic signed [N-1:0]   y = '0;
   logic                  busy, done;
   logic [2*N-1:0]        product;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic signed [2*N-1:0] exp_q[$];
   logic done_prev = 1'b0;

   always #10 clk = ~clk;

   booth_seq_mult #(.N(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .x(x), .y(y),
      .busy(busy), .done(done), .product(product)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Monitor: pop on each completion and compare (R2, R3, R4, R8).
   always @(negedge clk) begin
      if (rst_n && done && !done_prev) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", longint'($signed(product)), 0);
         end else begin
            logic signed [2*N-1:0] e;
            e = exp_q.pop_front();
            check($signed(product) == e, "R2 product", longint'($signed(product)), longint'(e));
         end
      end
      done_prev = done;
   end

   // Driver: one request, expected value into the scoreboard, wait for completion.
   task automatic run_mul(input logic signed [N-1:0] a, input logic signed [N-1:0] b,
                          input bit chk_lat);
      int cnt;
      logic signed [2*N-1:0] e;
      while (busy) @(negedge clk);
      x = a;
      y = b;
      start = 1'b1;
      e = a * b;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      if (chk_lat) check(busy && !done, "R5 busy after accept", longint'(busy), 1);
      while (!done) begin
         @(negedge clk);
         cnt++;
      end
      if (chk_lat) check(cnt == N/2 + 1, "R5 latency", cnt, N/2 + 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      wrap_up();
   end

   initial begin
      logic signed [N-1:0] ylist[24];
      logic [2*N-1:0] held;
      ylist = '{8'sh00, 8'sh01, 8'sh02, 8'sh03, 8'sh04, 8'sh05, 8'sh06, 8'sh07,
                8'sh0C, 8'sh30, 8'shC0, 8'sh18, 8'sh60, 8'sh55, 8'shAA, 8'sh7F,
                8'sh80, 8'sh81, 8'shFF, 8'shFE, 8'shFD, 8'shF9, 8'sh33, 8'shCC};

      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy", longint'(busy), 0);
      check(done == 1'b0, "R1 done", longint'(done), 0);
      check(product == '0, "R1 product", longint'(product), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: first window 110 -> -x, next 011 -> +2x at weight 4: 9*7 = 63
      run_mul(8'sd9, 8'sd7, 1'b1);
      check($signed(product) == 63, "R4 worked example", longint'($signed(product)), 63);

      // R8: extremes
      run_mul(-8'sd128, -8'sd128, 1'b1);
      check($signed(product) == 16384, "R8 most negative squared",
            longint'($signed(product)), 16384);
      run_mul(-8'sd128, 8'sd127, 1'b0);
      run_mul(8'sd127, 8'sd127, 1'b0);
      run_mul(8'sd0, -8'sd128, 1'b0);

      // R7: result and done held while start stays low
      held = product;
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R7 done held", longint'(done), 1);
      check(product == held, "R7 product held", longint'(product), longint'(held));

      // R6: stray start with other operands while busy
      x = 8'sd5;
      y = -8'sd3;
      start = 1'b1;
      exp_q.push_back(-16'sd15);
      @(negedge clk);
      check(done == 1'b0, "R7 done cleared on accept", longint'(done), 0);
      x = 8'sd100;
      y = 8'sd100;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      check($signed(product) == -15, "R6 stray start ignored", longint'($signed(product)), -15);
      @(negedge clk);
      check(busy == 1'b0, "R6 no extra run", longint'(busy), 0);
      check(exp_q.size() == 0, "R6 no extra result", exp_q.size(), 0);

      // R2, R3: all multiplicands against multipliers covering each window code
      for (int xi = -128; xi < 128; xi++) begin
         for (int k = 0; k < 24; k++) begin
            run_mul(N'(xi), ylist[k], (k == 0));
         end
      end

      @(negedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      wrap_up();
   end

endmodule